// File: doc/BRIEF.md
# 100 Mbit/s Link Monitor with Stabilize Timer

This block decides whether the 100 Mbit/s receive path has a usable link. On copper, a valid signal means that the energy detector sees activity on the wire and the descrambler has locked. In fiber mode, the external optical module's signal-detect line is the only qualifier. The valid indication must hold without a break for a stabilize interval before the block declares the link good. The interval is picked by a two-bit select from four lengths. A single missing sample during that window starts the count again from zero.

While the link is not good, the block tells the transmit path to send scrambled idle only. It also drives an active-low link LED. When a good link is lost, the block returns to the failed state at once and emits a one-clock event that the interrupt logic can mask. A force-link control makes the link report up without any qualification.

The interval counter runs on the PHY reference clock. `TICKS_PER_US` gives the number of reference clocks per microsecond, and the default of 25 matches a 25 MHz reference.

Top module: `link_mon_100x`

## Requirements
- R1: While `rst_n` is low, and immediately after it rises: `link_ok`=0, `tx_force_idle`=1, `link_led_n`=1, `link_fail_evt`=0.
- R2: In copper mode (`fiber_mode`=0), a sample counts as valid only when `energy_det`=1 and `desc_locked`=1. If either is 0, the sample is invalid.
- R3: In fiber mode (`fiber_mode`=1), a sample is valid exactly when `sd_fiber`=1. `energy_det` and `desc_locked` have no effect.
- R4: From the failed state, `link_ok` reads 1 in the cycle that follows the N-th consecutive rising clock edge at which the sample was valid. N = interval_us × `TICKS_PER_US`.
- R5: `stab_sel` selects the interval: 00 gives 700 us, 01 gives 1000 us, 10 gives 5000 us, 11 gives 45000 us.
- R6: An invalid sample during qualification resets the count to zero. The next valid sample then starts a new full interval.
- R7: When a good link sees an invalid sample at an edge, `link_ok` drops after that edge. In that same cycle `link_fail_evt` is 1, and it lasts exactly one cycle.
- R8: `tx_force_idle` is 1 whenever `link_ok` is 0, and 0 whenever `link_ok` is 1.
- R9: `link_led_n` is active low: 0 when `link_ok` is 1, and 1 otherwise.
- R10: While `force_link`=1, `link_ok`=1, `tx_force_idle`=0 and `link_led_n`=0 combinationally. No `link_fail_evt` is produced while forced. Qualification keeps running underneath.
- R11: A change of `stab_sel` during qualification takes effect immediately and does not reset the count. If the count already meets the new length, the link passes at the next valid edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for the interval counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fiber_mode | input | 1 | 1 = qualify on the fiber signal-detect line |
| energy_det | input | 1 | Copper energy-detect indication |
| desc_locked | input | 1 | Descrambler lock flag |
| sd_fiber | input | 1 | Signal detect from the fiber module |
| stab_sel | input | 2 | Stabilize interval select |
| force_link | input | 1 | Report link up without qualification |
| link_ok | output | 1 | Link status, 1 = good |
| tx_force_idle | output | 1 | 1 = transmit path sends idle only |
| link_led_n | output | 1 | Link LED, active low |
| link_fail_evt | output | 1 | One-cycle pulse on loss of a good link |

## Verification
The embedded assertions check properties that hold on every cycle:
- the counter reloads on any invalid sample and otherwise steps by one;
- the pass transition happens only when the timer has reached its count;
- a good link drops on the first invalid sample;
- the fail event never lasts two cycles;
- the forced-link outputs are correct.

The exact interval lengths for each select code and the fiber/copper qualifier choice can only be shown by the bench's timed scenarios. The same holds for restarting after a mid-window dropout, for a select change mid-count, and for suppressing the event under force. The bench compares all four outputs with a behavioural model on every clock.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic {
    LM_FAIL = 1'b0,
    LM_PASS = 1'b1
  } lm_state_e;

  localparam int unsigned LM_MAX_US = 45000;

  function automatic int unsigned lm_interval_us(input logic [1:0] sel);
    case (sel)
      2'b00:   return 700;
      2'b01:   return 1000;
      2'b10:   return 5000;
      default: return LM_MAX_US;
    endcase
  endfunction

endpackage

// File: rtl/lm_sig_qual.sv
module lm_sig_qual (
  input  logic fiber_mode,
  input  logic energy_det,
  input  logic desc_locked,
  input  logic sd_fiber,
  output logic sig_valid
);

  logic copper_ok;

  assign copper_ok = energy_det & desc_locked;

  always_comb begin
    if (fiber_mode) sig_valid = sd_fiber;
    else            sig_valid = copper_ok;
  end

endmodule

// File: rtl/lm_stab_timer.sv
module lm_stab_timer #(
  parameter int unsigned TICKS_PER_US = 25,
  parameter int unsigned CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    sel,
  output logic          done
);
  import lm_pkg::*;

  logic [CW-1:0] term_m1 [4];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  for (genvar g = 0; g < 4; g++) begin : g_term
    assign term_m1[g] = CW'(lm_interval_us(2'(g)) * TICKS_PER_US - 1);
  end

  assign done   = (cnt_q >= term_m1[sel]);
  assign cnt_en = run | (cnt_q != '0);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (done) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6: any invalid sample reloads the counter
  assert_reload_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R4: qualification advances by exactly one per valid edge
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lm_link_fsm.sv
module lm_link_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_valid,
  input  logic tmr_done,
  input  logic force_link,
  output logic tmr_run,
  output logic link_pass,
  output logic fail_evt
);
  import lm_pkg::*;

  lm_state_e state_q, state_d;
  logic      fail_evt_q, fail_evt_d;

  always_comb begin
    state_d    = state_q;
    fail_evt_d = 1'b0;
    tmr_run    = 1'b0;
    case (state_q)
      LM_FAIL: begin
        tmr_run = sig_valid;
        if (sig_valid && tmr_done) state_d = LM_PASS;
      end
      LM_PASS: begin
        if (!sig_valid) begin
          state_d    = LM_FAIL;
          fail_evt_d = ~force_link;
        end
      end
      default: state_d = LM_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LM_FAIL;
      fail_evt_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      fail_evt_q <= fail_evt_d;
    end
  end

  assign link_pass = (state_q == LM_PASS);
  assign fail_evt  = fail_evt_q;

  // R7: event is a single-cycle pulse
  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt_q |=> !fail_evt_q);

  // R7: a good link falls on the first invalid sample
  assert_drop_exits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_pass && !sig_valid) |=> !link_pass);

  // R4: pass is entered only with the timer at its count
  assert_pass_needs_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_pass && !(sig_valid && tmr_done)) |=> !link_pass);

endmodule

// File: rtl/link_mon_100x.sv
module link_mon_100x #(
  parameter int unsigned TICKS_PER_US = 25
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       fiber_mode,
  input  logic       energy_det,
  input  logic       desc_locked,
  input  logic       sd_fiber,
  input  logic [1:0] stab_sel,
  input  logic       force_link,
  output logic       link_ok,
  output logic       tx_force_idle,
  output logic       link_led_n,
  output logic       link_fail_evt
);
  import lm_pkg::*;

  localparam int unsigned MAX_TICKS = LM_MAX_US * TICKS_PER_US;
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

  logic sig_valid;
  logic tmr_run;
  logic tmr_done;
  logic link_pass;

  lm_sig_qual u_qual (
    .fiber_mode  (fiber_mode),
    .energy_det  (energy_det),
    .desc_locked (desc_locked),
    .sd_fiber    (sd_fiber),
    .sig_valid   (sig_valid)
  );

  lm_stab_timer #(
    .TICKS_PER_US (TICKS_PER_US),
    .CW           (CW)
  ) u_timer (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .run   (tmr_run),
    .sel   (stab_sel),
    .done  (tmr_done)
  );

  lm_link_fsm u_fsm (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .sig_valid  (sig_valid),
    .tmr_done   (tmr_done),
    .force_link (force_link),
    .tmr_run    (tmr_run),
    .link_pass  (link_pass),
    .fail_evt   (link_fail_evt)
  );

  assign link_ok       = link_pass | force_link;
  assign tx_force_idle = ~link_ok;
  assign link_led_n    = ~link_ok;

  // R10: forced link overrides every output
  assert_force_up_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    force_link |-> (link_ok && !tx_force_idle && !link_led_n && !link_fail_evt));

  // R7: event only accompanies a link that just went down
  assert_evt_on_loss_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    link_fail_evt |-> (!link_pass && $past(link_pass)));

endmodule

// File: tb/link_mon_100x_test.sv
`timescale 1ns/1ps
module link_mon_100x_test;

  localparam int TPU = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fiber_mode = 1'b0;
  logic       energy_det = 1'b0;
  logic       desc_locked = 1'b0;
  logic       sd_fiber = 1'b0;
  logic [1:0] stab_sel = 2'b00;
  logic       force_link = 1'b0;
  logic       link_ok, tx_force_idle, link_led_n, link_fail_evt;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  link_mon_100x #(.TICKS_PER_US(TPU)) uut (
    .clk_ref       (clk),
    .rst_n         (rst_n),
    .fiber_mode    (fiber_mode),
    .energy_det    (energy_det),
    .desc_locked   (desc_locked),
    .sd_fiber      (sd_fiber),
    .stab_sel      (stab_sel),
    .force_link    (force_link),
    .link_ok       (link_ok),
    .tx_force_idle (tx_force_idle),
    .link_led_n    (link_led_n),
    .link_fail_evt (link_fail_evt)
  );

  // behavioural reference model
  int m_consec = 0;
  bit m_pass = 0;
  bit m_evt = 0;

  function automatic int req_len(input logic [1:0] s);
    case (s)
      2'b00: return 700 * TPU;
      2'b01: return 1000 * TPU;
      2'b10: return 5000 * TPU;
      default: return 45000 * TPU;
    endcase
  endfunction

  always @(posedge clk) begin
    bit v;
    if (!rst_n) begin
      m_consec = 0; m_pass = 0; m_evt = 0;
    end else begin
      v = fiber_mode ? sd_fiber : (energy_det && desc_locked);
      m_evt = 0;
      if (m_pass) begin
        if (!v) begin m_pass = 0; m_consec = 0; m_evt = !force_link; end
      end else if (v) begin
        m_consec++;
        if (m_consec >= req_len(stab_sel)) begin m_pass = 1; m_consec = 0; end
      end else begin
        m_consec = 0;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      bit el;
      el = m_pass | force_link;
      chk(link_ok,       el,    "R4 link_ok vs model");
      chk(tx_force_idle, !el,   "R8 tx_force_idle vs model");
      chk(link_led_n,    !el,   "R9 link_led_n vs model");
      chk(link_fail_evt, m_evt, "R7 link_fail_evt vs model");
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic at_neg;
    @(negedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    at_neg;
    chk(link_ok, 1'b0, "R1 reset link_ok");
    chk(tx_force_idle, 1'b1, "R1 reset idle");
    chk(link_led_n, 1'b1, "R1 reset led");
    chk(link_fail_evt, 1'b0, "R1 reset evt");
    rst_n = 1'b1;
    step(2);
    at_neg;
    chk(link_ok, 1'b0, "R1 after release");

    // R5 sel=00, copper valid
    stab_sel = 2'b00; energy_det = 1; desc_locked = 1;
    step(699); at_neg;
    chk(link_ok, 1'b0, "R5 700 not yet");
    step(1); at_neg;
    chk(link_ok, 1'b1, "R4 pass at 700");
    chk(link_led_n, 1'b0, "R9 led on");

    // R7 loss: energy drop (R2)
    energy_det = 0;
    step(1); at_neg;
    chk(link_ok, 1'b0, "R7 drop");
    chk(link_fail_evt, 1'b1, "R7 evt");
    chk(tx_force_idle, 1'b1, "R8 idle on fail");
    step(1); at_neg;
    chk(link_fail_evt, 1'b0, "R7 evt one cycle");

    // R2 locked low keeps link down
    energy_det = 1; desc_locked = 0;
    step(800); at_neg;
    chk(link_ok, 1'b0, "R2 unlocked");

    // R6 dropout restart, sel=01
    stab_sel = 2'b01; desc_locked = 1;
    step(600);
    energy_det = 0; step(1);
    energy_det = 1;
    step(999); at_neg;
    chk(link_ok, 1'b0, "R6 restarted count");
    step(1); at_neg;
    chk(link_ok, 1'b1, "R6 pass after full interval");
    energy_det = 0; step(2);

    // R3 fiber mode
    fiber_mode = 1; sd_fiber = 1; energy_det = 0; desc_locked = 0; stab_sel = 2'b00;
    step(700); at_neg;
    chk(link_ok, 1'b1, "R3 fiber sd only");
    energy_det = 1; desc_locked = 1; sd_fiber = 0;
    step(1); at_neg;
    chk(link_ok, 1'b0, "R3 fiber ignores copper");
    chk(link_fail_evt, 1'b1, "R7 evt fiber");

    // R5 sel=10 and sel=11
    stab_sel = 2'b10; sd_fiber = 1;
    step(4999); at_neg; chk(link_ok, 1'b0, "R5 5000 not yet");
    step(1);    at_neg; chk(link_ok, 1'b1, "R5 5000 pass");
    sd_fiber = 0; step(2);
    stab_sel = 2'b11; sd_fiber = 1;
    step(44999); at_neg; chk(link_ok, 1'b0, "R5 45000 not yet");
    step(1);     at_neg; chk(link_ok, 1'b1, "R5 45000 pass");

    // R10 force link
    sd_fiber = 0; step(2);
    force_link = 1; #1;
    chk(link_ok, 1'b1, "R10 forced up");
    chk(tx_force_idle, 1'b0, "R10 no idle");
    stab_sel = 2'b00; sd_fiber = 1;
    step(700);
    sd_fiber = 0;
    step(1); at_neg;
    chk(link_fail_evt, 1'b0, "R10 no evt while forced");
    force_link = 0; #1;
    chk(link_ok, 1'b0, "R10 release shows real state");

    // R11 select change mid-count
    stab_sel = 2'b11; sd_fiber = 1;
    step(3000);
    stab_sel = 2'b00;
    step(1); at_neg;
    chk(link_ok, 1'b1, "R11 shorter select passes");

    step(5);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule